// File: doc/BRIEF.md
# Special Register and Stack Unit

This block keeps the program counter, the stack pointer and the link register of a 32-bit processor model. It also holds a small word-addressed stack memory that the stack pointer indexes. The stack grows downward and SP always points at the last word written. A bundle of command request bits arrives on a valid/ready stream, and the unit performs one operation per accepted cycle. The operations are:

- a sequential fetch step;
- a push;
- a pop to the data output;
- a branch-and-link;
- a return through LR;
- a PC-relative branch;
- a pop straight into PC.

A popped word leaves on a valid/ready output stream. Back-pressure works as follows. While a popped word is waiting and the consumer holds `pop_ready` low, `cmd_ready` is low. During that time no command is accepted and all registers hold. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. An accepted command with no request bit set does nothing.

Top module: `sru_top`

## Requirements
- R1: A synchronous active-high reset sets PC to 0, SP to the `STACK_TOP` parameter (default 0x2000) and LR to 0, and clears `pop_valid`.
- R2: A fetch step (request bit 0) adds 4 to PC. From 0x8000, three steps give 0x800C.
- R3: A push (bit 1) first subtracts 4 from SP, then stores `cmd_wdata` at the new SP address.
- R4: A pop (bit 2) reads the word at the current SP and then adds 4 to SP. On the next cycle `pop_valid` is high and `pop_data` holds that word. From SP=0x2000, pushing 0x11 then 0x22 and popping once yields 0x22 with SP=0x1FFC.
- R5: A branch-and-link (bit 3) writes PC+4 into LR, replacing any earlier value, and loads `cmd_target` into PC.
- R6: A return (bit 4) loads PC from LR.
- R7: A relative branch (bit 5) sets PC to PC + 8 + 4 × sign-extended 24-bit `cmd_offset`. From 0x1000 with offset -3 (0xFFFFFD), PC becomes 0x0FFC.
- R8: A pop into PC (bit 6) loads the word at SP into PC and adds 4 to SP. It does not raise `pop_valid`.
- R9: When several request bits are set in an accepted cycle, only the lowest-numbered one is performed. When `cmd_valid` is low, nothing changes.
- R10: While `pop_valid` is high and `pop_ready` is low, `pop_data` stays stable and `cmd_ready` is low. In that state no command changes PC, SP or LR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command bundle present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_sel | input | 7 | Request bits, index 0 has highest priority |
| cmd_wdata | input | 32 | Word to push |
| cmd_target | input | 32 | Absolute branch-and-link target |
| cmd_offset | input | 24 | Signed relative-branch instruction count |
| pc | output | 32 | Program counter |
| sp | output | 32 | Stack pointer |
| lr | output | 32 | Link register |
| pop_valid | output | 1 | Popped word available |
| pop_ready | input | 1 | Consumer accepts popped word |
| pop_data | output | 32 | Popped word |

## Verification
Every register is visible at the ports, so a wrong PC, SP or LR update shows on the cycle after the accepted command. A wrong memory address stays hidden until the word is popped back. The bench therefore follows each push with a pop, and checks both the returned value and its order. A priority or back-pressure fault appears as a register that moved when it should have held. The bench samples every port at the negative edge right after the operation's clock edge.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int NUM_CMDS = 7;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FETCH = 3'd1,
    OP_PUSH  = 3'd2,
    OP_POP   = 3'd3,
    OP_BL    = 3'd4,
    OP_RET   = 3'd5,
    OP_RELB  = 3'd6,
    OP_POPPC = 3'd7
  } op_e;
endpackage

// File: rtl/sru_arbiter.sv
module sru_arbiter
  import sru_pkg::*;
#(
  parameter int N = NUM_CMDS
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output op_e          op
);
  always_comb begin
    op = OP_NONE;
    if (en) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (req[i]) op = op_e'(3'(i + 1));
      end
    end
  end

  // a_r9_lowest_wins: the chosen op is the lowest set request
  always_comb begin
    if (en && req[0]) a_r9_lowest_wins: assert (op == OP_FETCH);
  end
endmodule

// File: rtl/sru_pc_unit.sv
module sru_pc_unit
  import sru_pkg::*;
#(
  parameter int W     = 32,
  parameter int OFF_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [W-1:0]     target,
  input  logic [OFF_W-1:0] offset,
  input  logic [W-1:0]     stack_word,
  output logic [W-1:0]     pc,
  output logic [W-1:0]     lr
);
  localparam logic [W-1:0] STEP     = W'(4);
  localparam logic [W-1:0] PIPE_ADJ = W'(8);

  logic [W-1:0] off_ext;
  logic [W-1:0] rel_tgt;
  logic [W-1:0] pc_nxt;
  logic [W-1:0] lr_nxt;

  assign off_ext = {{(W - OFF_W){offset[OFF_W-1]}}, offset};
  assign rel_tgt = pc + PIPE_ADJ + (off_ext << 2);

  always_comb begin
    pc_nxt = pc;
    lr_nxt = lr;
    unique case (op)
      OP_FETCH: pc_nxt = pc + STEP;
      OP_BL: begin
        lr_nxt = pc + STEP;
        pc_nxt = target;
      end
      OP_RET:   pc_nxt = lr;
      OP_RELB:  pc_nxt = rel_tgt;
      OP_POPPC: pc_nxt = stack_word;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      lr <= '0;
    end else begin
      pc <= pc_nxt;
      lr <= lr_nxt;
    end
  end

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    op == OP_FETCH |=> pc == $past(pc) + STEP);
  a_r5_link_saved: assert property (@(posedge clk) disable iff (rst)
    op == OP_BL |=> lr == $past(pc) + STEP && pc == $past(target));
  a_r6_return_lr: assert property (@(posedge clk) disable iff (rst)
    op == OP_RET |=> pc == $past(lr));
  a_r7_rel_branch: assert property (@(posedge clk) disable iff (rst)
    op == OP_RELB |=> pc == $past(pc) + PIPE_ADJ + ($past(off_ext) << 2));
  a_r8_pop_into_pc: assert property (@(posedge clk) disable iff (rst)
    op == OP_POPPC |=> pc == $past(stack_word));
endmodule

// File: rtl/sru_stack.sv
module sru_stack
  import sru_pkg::*;
#(
  parameter int          W         = 32,
  parameter int          DEPTH     = 16,
  parameter logic [31:0] STACK_TOP = 32'h0000_2000
) (
  input  logic         clk,
  input  logic         rst,
  input  op_e          op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sp,
  output logic [W-1:0] rd_word
);
  localparam int           IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [W-1:0] WORD  = W'(4);

  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     sp_dec;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             is_pop;

  assign sp_dec  = sp - WORD;
  assign rd_idx  = sp[IDX_W+1:2];
  assign wr_idx  = sp_dec[IDX_W+1:2];
  assign rd_word = mem[rd_idx];
  assign is_pop  = (op == OP_POP) || (op == OP_POPPC);

  always_ff @(posedge clk) begin
    if (op == OP_PUSH) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                sp <= W'(STACK_TOP);
    else if (op == OP_PUSH) sp <= sp_dec;
    else if (is_pop)        sp <= sp + WORD;
  end

  a_r3_push_predec: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> sp == $past(sp) - WORD);
  a_r4_pop_postinc: assert property (@(posedge clk) disable iff (rst)
    is_pop |=> sp == $past(sp) + WORD);
  a_r3_push_written: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> rd_word == $past(wdata));
endmodule

// File: rtl/sru_top.sv
module sru_top
  import sru_pkg::*;
#(
  parameter int          W         = 32,
  parameter int          OFF_W     = 24,
  parameter int          DEPTH     = 16,
  parameter logic [31:0] STACK_TOP = 32'h0000_2000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [NUM_CMDS-1:0] cmd_sel,
  input  logic [W-1:0]        cmd_wdata,
  input  logic [W-1:0]        cmd_target,
  input  logic [OFF_W-1:0]    cmd_offset,
  output logic [W-1:0]        pc,
  output logic [W-1:0]        sp,
  output logic [W-1:0]        lr,
  output logic                pop_valid,
  input  logic                pop_ready,
  output logic [W-1:0]        pop_data
);
  op_e          op;
  logic         fire;
  logic [W-1:0] rd_word;

  assign cmd_ready = !pop_valid || pop_ready;
  assign fire      = cmd_valid && cmd_ready;

  sru_arbiter #(.N(NUM_CMDS)) arb_i (
    .en (fire),
    .req(cmd_sel),
    .op (op)
  );

  sru_pc_unit #(.W(W), .OFF_W(OFF_W)) pcu_i (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .target    (cmd_target),
    .offset    (cmd_offset),
    .stack_word(rd_word),
    .pc        (pc),
    .lr        (lr)
  );

  sru_stack #(.W(W), .DEPTH(DEPTH), .STACK_TOP(STACK_TOP)) stk_i (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .wdata  (cmd_wdata),
    .sp     (sp),
    .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else if (op == OP_POP) begin
      pop_valid <= 1'b1;
      pop_data  <= rd_word;
    end else if (pop_ready) begin
      pop_valid <= 1'b0;
    end
  end

  a_r4_pop_out: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |=> pop_valid && pop_data == $past(rd_word));
  a_r8_no_pop_out: assert property (@(posedge clk) disable iff (rst)
    op == OP_POPPC |=> !pop_valid);
  a_r10_hold_data: assert property (@(posedge clk) disable iff (rst)
    pop_valid && !pop_ready |=> pop_valid && $stable(pop_data));
  a_r10_stall_regs: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> $stable(pc) && $stable(sp) && $stable(lr));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(pc) && $stable(sp) && $stable(lr));
endmodule

// File: tb/sru_top_tb_top.sv
module sru_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [6:0]  cmd_sel;
  logic [31:0] cmd_wdata, cmd_target;
  logic [23:0] cmd_offset;
  logic [31:0] pc, sp, lr, pop_data;
  logic        pop_valid, pop_ready;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sru_top dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata), .cmd_target(cmd_target),
    .cmd_offset(cmd_offset), .pc(pc), .sp(sp), .lr(lr),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge, release and sample at next negedge
  task automatic cmd(logic [6:0] sel, logic [31:0] wd = 0,
                     logic [31:0] tg = 0, logic [23:0] off = 0, logic vld = 1);
    @(negedge clk);
    cmd_valid = vld; cmd_sel = sel; cmd_wdata = wd;
    cmd_target = tg; cmd_offset = off;
    @(negedge clk);
    cmd_valid = 0; cmd_sel = 0;
  endtask

  task automatic t_reset;
    chk("R1 pc", pc, 32'h0);
    chk("R1 sp", sp, 32'h2000);
    chk("R1 lr", lr, 32'h0);
    chk("R1 pop_valid", {31'b0, pop_valid}, 32'h0);
  endtask

  task automatic t_fetch;
    cmd(7'b000_1000, 0, 32'h8000);
    chk("R5 lr after bl", lr, 32'h4);
    chk("R5 pc after bl", pc, 32'h8000);
    for (int i = 0; i < 3; i++) cmd(7'b000_0001);
    chk("R2 three fetches", pc, 32'h800C);
  endtask

  task automatic t_stack;
    cmd(7'b000_0010, 32'h11);
    chk("R3 sp after push", sp, 32'h1FFC);
    cmd(7'b000_0010, 32'h22);
    chk("R3 sp after 2nd push", sp, 32'h1FF8);
    cmd(7'b000_0100);
    chk("R4 pop_valid", {31'b0, pop_valid}, 32'h1);
    chk("R4 pop data", pop_data, 32'h22);
    chk("R4 sp after pop", sp, 32'h1FFC);
    cmd(7'b000_0100);
    chk("R4 second pop data", pop_data, 32'h11);
    chk("R4 sp balanced", sp, 32'h2000);
  endtask

  task automatic t_call_ret;
    cmd(7'b000_1000, 0, 32'h1000);
    chk("R5 lr overwritten", lr, 32'h8010);
    cmd(7'b001_0000);
    chk("R6 return", pc, 32'h8010);
  endtask

  task automatic t_rel;
    cmd(7'b000_1000, 0, 32'h1000);
    cmd(7'b010_0000, 0, 0, 24'hFFFFFD);
    chk("R7 backward", pc, 32'h0FFC);
    cmd(7'b010_0000, 0, 0, 24'd2);
    chk("R7 forward", pc, 32'h100C);
  endtask

  task automatic t_poppc;
    cmd(7'b000_0010, 32'h4444);
    cmd(7'b100_0000);
    chk("R8 pc loaded", pc, 32'h4444);
    chk("R8 sp restored", sp, 32'h2000);
    chk("R8 no pop_valid", {31'b0, pop_valid}, 32'h0);
  endtask

  task automatic t_priority;
    cmd(7'b000_0011, 32'h99);
    chk("R9 fetch wins pc", pc, 32'h4448);
    chk("R9 push dropped sp", sp, 32'h2000);
    cmd(7'b110_0000, 0, 0, 24'd0);
    chk("R9 rel wins pc", pc, 32'h4450);
    chk("R9 rel wins sp", sp, 32'h2000);
    cmd(7'b000_0001, 0, 0, 0, 1'b0);
    chk("R9 invalid ignored", pc, 32'h4450);
  endtask

  task automatic t_backpressure;
    cmd(7'b000_0010, 32'hABCD);
    @(negedge clk); pop_ready = 0;
    cmd(7'b000_0100);
    chk("R10 pop held valid", {31'b0, pop_valid}, 32'h1);
    chk("R10 cmd_ready low", {31'b0, cmd_ready}, 32'h0);
    cmd(7'b000_0001);
    chk("R10 stalled pc", pc, 32'h4450);
    chk("R10 data stable", pop_data, 32'hABCD);
    chk("R10 still valid", {31'b0, pop_valid}, 32'h1);
    pop_ready = 1;
    @(negedge clk);
    chk("R10 drained", {31'b0, pop_valid}, 32'h0);
    cmd(7'b000_0001);
    chk("R10 resumes", pc, 32'h4454);
  endtask

  initial begin
    rst = 1; cmd_valid = 0; cmd_sel = 0; cmd_wdata = 0;
    cmd_target = 0; cmd_offset = 0; pop_ready = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fetch();
    t_stack();
    t_call_ret();
    t_rel();
    t_poppc();
    t_priority();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule